// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block lets a small in-order core repeat a run of instructions a set number of times without spending any cycles on a branch. The core presents the address of the instruction that completes in each cycle. When that instruction is a loop instruction, the core also raises a start strobe with the instruction's count operands and its jump offset. The block records where the body begins, where it ends and how many passes remain. From then on it watches the instruction stream. When the sequential next address would land on the recorded end, it takes a pass off the count. If passes remain, it steers the fetch address back to the first body instruction. If none remain, it lets execution fall through to the end address.

The count comes from one of two places. A register source supplies its low bits directly. An 8-bit immediate source is biased by one, so an immediate can never produce a zero count. A zero count starts no loop. Instead, the next address becomes the end address at once, which skips the body. The block always drives the next fetch address, so the core can use `next_pc_o` directly and treat `redirect_o` only as a hint that the flow was not sequential. Only one loop is tracked at a time. A new loop instruction with a nonzero count replaces whatever loop was in progress.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset `loop_active_o` is 0, and no redirect occurs until a loop is started.
- R2: With `imm_sel_i` = 1, the pass count is `imm_i` + 1 (1 to 256). The body therefore runs that many times, with one fewer redirects to the body start.
- R3: With `imm_sel_i` = 0, the pass count is `reg_cnt_i` taken as an unsigned value.
- R4: A start with a count of 0 asserts `redirect_o` in the same cycle with `next_pc_o` = `pc_i` + `jmp_ofs_i`, and does not set `loop_active_o`.
- R5: A start with a nonzero count does not redirect in that cycle (`next_pc_o` = `pc_i` + 1). `loop_active_o` is 1 from the next cycle.
- R6: While a loop is active, suppose `pc_i` + 1 equals the recorded end (start address + `jmp_ofs_i`) and more than one pass remains. Then `redirect_o` = 1 and `next_pc_o` = start address + 1.
- R7: At the end of the last pass, no redirect occurs (`next_pc_o` = `pc_i` + 1). `loop_active_o` drops to 0 in the next cycle.
- R8: A start with a nonzero count while a loop is active replaces that loop entirely. A start cycle never counts as reaching the old loop's end.
- R9: Cycles in which `pc_i` + 1 differs from the recorded end leave the pass count and `loop_active_o` unchanged. With no loop active and no start, `redirect_o` is 0.
- R10: Whenever `redirect_o` is 0, `next_pc_o` = `pc_i` + 1, wrapping at the address width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | PC_W | Address of the instruction completing this cycle |
| loop_start_i | input | 1 | Completing instruction is a loop instruction |
| imm_sel_i | input | 1 | 1: count from immediate, 0: count from register |
| imm_i | input | 8 | Immediate count operand (count = value + 1) |
| reg_cnt_i | input | CNT_W | Low bits of the register count operand |
| jmp_ofs_i | input | OFS_W | Distance from the loop instruction to the loop end |
| redirect_o | output | 1 | Next address is not sequential |
| next_pc_o | output | PC_W | Next fetch address |
| loop_active_o | output | 1 | A loop is in progress |

## Verification
Directed runs cover three count cases. A one-instruction body with immediate 255 checks that the biased count reaches 256 passes rather than wrapping. Register counts of 0 and 5 separate skipping the body from running it. A replacement start issued in the middle of a loop shows whether stale end or count state survives. Random runs scatter loop instructions of both count sources, small counts and short offsets through a stream that follows `next_pc_o`. Many loops therefore end, restart or are overwritten at arbitrary points. A reference model checks every cycle, which tells an off-by-one at the end match apart from a wrong decrement or a wrong target.

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             loop_start_i,
  input  logic             imm_sel_i,
  input  logic [7:0]       imm_i,
  input  logic [CNT_W-1:0] reg_cnt_i,
  input  logic [OFS_W-1:0] jmp_ofs_i,
  output logic             redirect_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             loop_active_o
);

  localparam int IMM_PAD = CNT_W - 8;
  localparam int OFS_PAD = PC_W - OFS_W;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  top_q, end_q;

  logic [CNT_W-1:0] new_cnt, cnt_dec;
  logic [PC_W-1:0]  seq_pc, new_end;
  logic             start_zero, start_go, at_end, more, back;

  assign new_cnt    = imm_sel_i ? {{IMM_PAD{1'b0}}, imm_i} + CNT_W'(1) : reg_cnt_i;
  assign seq_pc     = pc_i + PC_W'(1);
  assign new_end    = pc_i + {{OFS_PAD{1'b0}}, jmp_ofs_i};
  assign start_zero = loop_start_i && (new_cnt == '0);
  assign start_go   = loop_start_i && (new_cnt != '0);
  assign at_end     = active_q && !loop_start_i && (seq_pc == end_q);
  assign cnt_dec    = cnt_q - CNT_W'(1);
  assign more       = cnt_dec != '0;
  assign back       = at_end && more;

  assign redirect_o    = start_zero || back;
  assign next_pc_o     = start_zero ? new_end : (back ? top_q : seq_pc);
  assign loop_active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      top_q    <= '0;
      end_q    <= '0;
    end else if (start_go) begin
      active_q <= 1'b1;
      cnt_q    <= new_cnt;
      top_q    <= seq_pc;
      end_q    <= new_end;
    end else if (at_end) begin
      cnt_q <= cnt_dec;
      if (!more) active_q <= 1'b0;
    end
  end

endmodule

module hwloop_ctrl_chk #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  pc_i,
  input logic             loop_start_i,
  input logic             imm_sel_i,
  input logic [7:0]       imm_i,
  input logic [CNT_W-1:0] reg_cnt_i,
  input logic [OFS_W-1:0] jmp_ofs_i,
  input logic             redirect_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             loop_active_o
);

  logic             cnt_zero;
  logic [PC_W-1:0]  seen_end;

  assign cnt_zero = imm_sel_i ? 1'b0 : (reg_cnt_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_end <= '0;
    else if (loop_start_i && !cnt_zero) seen_end <= pc_i + PC_W'(jmp_ofs_i);
  end

  AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start_i && !cnt_zero |=> loop_active_o);  // R5
  AST_START_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start_i && !cnt_zero |-> !redirect_o);  // R5
  AST_ZERO_NO_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start_i && cnt_zero && !loop_active_o |=> !loop_active_o);  // R4
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_active_o && !loop_start_i |-> !redirect_o);  // R9
  AST_HOLD_AWAY_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active_o && !loop_start_i && (pc_i + PC_W'(1)) != seen_end |=> loop_active_o);  // R9
  AST_SEQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> next_pc_o == pc_i + PC_W'(1));  // R10

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .loop_start_i(loop_start_i),
  .imm_sel_i(imm_sel_i), .imm_i(imm_i), .reg_cnt_i(reg_cnt_i), .jmp_ofs_i(jmp_ofs_i),
  .redirect_o(redirect_o), .next_pc_o(next_pc_o), .loop_active_o(loop_active_o));

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc = '0;
  logic        st = 1'b0, sel = 1'b0;
  logic [7:0]  imm = '0;
  logic [15:0] rc = '0;
  logic [7:0]  ofs = '0;
  logic        redir, act;
  logic [15:0] npc;

  int errs = 0, checks = 0, redirs = 0;
  bit m_act = 0;
  int m_cnt = 0;
  logic [15:0] m_top = '0, m_end = '0;

  always #5 clk = ~clk;

  hwloop_ctrl dut_i (.clk(clk), .rst_n(rst_n), .pc_i(pc), .loop_start_i(st),
    .imm_sel_i(sel), .imm_i(imm), .reg_cnt_i(rc), .jmp_ofs_i(ofs),
    .redirect_o(redir), .next_pc_o(npc), .loop_active_o(act));

  function automatic int count_of(bit s, logic [7:0] i, logic [15:0] r);
    return s ? int'(i) + 1 : int'(r);
  endfunction

  task automatic chk(bit ok, string req, int a, int e);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic step(bit s, bit sl, logic [7:0] i, logic [15:0] r, logic [7:0] o);
    bit e_ovr; logic [15:0] e_npc; int c;
    st = s; sel = sl; imm = i; rc = r; ofs = o;
    #2;
    c = count_of(sl, i, r);
    e_ovr = 0; e_npc = pc + 16'd1;
    if (s && c == 0) begin e_ovr = 1; e_npc = pc + 16'(o); end
    else if (!s && m_act && pc + 16'd1 == m_end && m_cnt - 1 != 0) begin
      e_ovr = 1; e_npc = m_top;
    end
    chk(act == m_act, "R9 loop_active", int'(act), int'(m_act));
    chk(redir == e_ovr, "R6/R7 redirect", int'(redir), int'(e_ovr));
    chk(npc == e_npc, "R10 next_pc", int'(npc), int'(e_npc));
    if (redir) redirs++;
    if (s && c != 0) begin
      m_act = 1; m_cnt = c; m_top = pc + 16'd1; m_end = pc + 16'(o);
    end else if (!s && m_act && pc + 16'd1 == m_end) begin
      m_cnt--; if (m_cnt == 0) m_act = 0;
    end
    @(negedge clk);
    pc = e_npc;
  endtask

  task automatic run_out(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(act == 0, "R1 active after reset", int'(act), 0);
    chk(redir == 0, "R1 no redirect in reset", int'(redir), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pc = 16'd100;
    run_out(5);
    chk(redirs == 0, "R1 no redirect idle", redirs, 0);

    // R2: immediate 2 -> 3 passes, 2 redirects
    pc = 16'd100; redirs = 0;
    step(1, 1, 8'd2, 16'd0, 8'd4);
    chk(act == 1, "R5 active after start", int'(act), 1);
    run_out(12);
    chk(redirs == 2, "R2 imm 2 redirects", redirs, 2);
    chk(act == 0, "R7 inactive after last pass", int'(act), 0);

    // R4: register count zero skips body
    pc = 16'd300; redirs = 0;
    st = 1; sel = 0; rc = 0; ofs = 8'd9; #2;
    chk(redir == 1, "R4 zero redirect", int'(redir), 1);
    chk(npc == 16'd309, "R4 zero target", int'(npc), 309);
    step(1, 0, 8'd0, 16'd0, 8'd9);
    chk(act == 0, "R4 no loop started", int'(act), 0);

    // R3: register count 5 -> 4 redirects
    pc = 16'd500; redirs = 0;
    step(1, 0, 8'd0, 16'd5, 8'd3);
    run_out(14);
    chk(redirs == 4, "R3 reg 5 redirects", redirs, 4);

    // R2 boundary: immediate 255 -> 256 passes of a one-instruction body
    pc = 16'd700; redirs = 0;
    step(1, 1, 8'd255, 16'd0, 8'd2);
    run_out(258);
    chk(redirs == 255, "R2 imm 255 redirects", redirs, 255);
    chk(act == 0, "R7 done after 256", int'(act), 0);

    // R8: replace a running loop
    pc = 16'd200; redirs = 0;
    step(1, 0, 8'd0, 16'd10, 8'd6);
    run_out(1);
    step(1, 1, 8'd0, 16'd0, 8'd3);
    run_out(8);
    chk(redirs == 0, "R8 replaced loop no redirect", redirs, 0);
    chk(act == 0, "R8 replaced loop finished", int'(act), 0);

    // Random stream
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 12 == 0)
        step(1, 1'($urandom % 2), 8'($urandom % 4), 16'($urandom % 5), 8'(2 + $urandom % 7));
      else
        step(0, 1'($urandom % 2), 8'($urandom), 16'($urandom), 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule